// File: doc/BRIEF.md
# Programmable Interrupting Interval Timer

A 64-bit interval timer owned by a single interruptible resource. Once enabled, it advances its count by a tick amount on every clock. The tick amount can be anywhere from 0 to 16. When the timer reaches its terminal condition, it raises a level interrupt request. Three terminal modes share one adder datapath:

- **Down:** count toward zero.
- **Up:** count from a negative preload toward zero.
- **Compare:** run freely against a separate match register.

At terminal the timer either stops (one-shot) or reloads from a reload register (periodic).

Software reaches every register through a simple memory-mapped port. Writes are synchronous and reads are combinational. Software can resynchronise the timer to an external time base by reading the count and writing a corrected value on the next access. The written value lands exactly: it overrides any tick arriving in that cycle. Because a single step can move the count by more than one, terminal detection uses crossing tests, not equality.

Top module: `pit_timer`

## Requirements
- R1: After reset, the count, match, reload and control registers read 0 and `irq_o` is low.
- R2: Down mode (control mode field 0) subtracts the tick amount each enabled cycle. Terminal occurs when the tick amount is nonzero and the count, taken as unsigned, is less than or equal to it.
- R3: Up mode (mode field 1) adds the tick amount each enabled cycle. Terminal occurs when that 64-bit addition carries out, meaning the count reaches or passes zero from a negative value.
- R4: Compare mode (mode field 2 or 3) adds the tick amount. Terminal occurs when the old count is below the match value and the unsigned sum is at or above it.
- R5: `tick_cnt_i` values above 16 advance the count by exactly 16.
- R6: One-shot terminal (control bit 3 = 0) clears the enable bit (control bit 0). The count is then left at 0 in down and up modes, or at the advanced value in compare mode.
- R7: Periodic terminal (control bit 3 = 1) loads the count from the reload register and leaves the enable bit set.
- R8: `irq_o` rises the cycle after a terminal and stays high until software writes a value with bit 0 set to the status address. Writing 0 there has no effect, and a terminal in the same cycle as a clear keeps `irq_o` high.
- R9: A write to the count register takes effect exactly on the next cycle. A tick in the same cycle is dropped and cannot cause a terminal.
- R10: The register map is as follows. Reads are combinational and unmapped addresses read 0.

  | Address | Register |
  |---------|----------|
  | 0 | control: bit 0 enable, bits 2:1 mode, bit 3 periodic |
  | 1 | count |
  | 2 | match |
  | 3 | reload |
  | 4 | status, bit 0 = pending |
- R11: While the enable bit is clear, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_cnt_i | input | 5 | Counts to add or subtract this cycle, saturated at 16 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
- **Down mode:** exercised with steps that land short of zero, followed by a step that overshoots it. This separates a crossing test from an equality test.
- **Up mode:** exercised from a negative preload with steps that stop at -1 and then pass zero. This checks that the carry, not the sign alone, triggers terminal and that the periodic reload takes place.
- **Compare mode:** driven to land exactly on the match value, which distinguishes `>=` from `>`.
- **Saturation and collisions:** an oversized tick and colliding write/tick and clear/terminal cycles expose clamping and priority errors.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  typedef enum logic [1:0] {
    MODE_DOWN = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_CMP2 = 2'd3
  } pit_mode_e;
endpackage

// File: rtl/pit_step.sv
module pit_step
  import pit_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int TICK_W   = 5,
  parameter int MAX_STEP = 16
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  match_i,
  input  pit_mode_e         mode_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [CNT_W-1:0]  next_o,
  output logic              hit_o
);
  localparam logic [TICK_W-1:0] STEP_CAP = TICK_W'(MAX_STEP);

  logic [TICK_W-1:0] step_t;
  logic [CNT_W-1:0]  step_w;
  logic [CNT_W:0]    sum;
  logic              moving;

  assign step_t = (tick_i > STEP_CAP) ? STEP_CAP : tick_i;
  assign step_w = CNT_W'(step_t);
  assign sum    = {1'b0, cnt_i} + {1'b0, step_w};
  assign moving = (step_t != '0);

  always_comb begin
    unique case (mode_i)
      MODE_DOWN: begin
        next_o = cnt_i - step_w;
        hit_o  = moving && (cnt_i <= step_w);
      end
      MODE_UP: begin
        next_o = sum[CNT_W-1:0];
        hit_o  = sum[CNT_W];
      end
      default: begin
        next_o = sum[CNT_W-1:0];
        hit_o  = moving && (cnt_i < match_i) && (sum >= {1'b0, match_i});
      end
    endcase
  end
endmodule

// File: rtl/pit_irq.sv
module pit_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);
  p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int TICK_W   = 5,
  parameter int MAX_STEP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TICK_W-1:0] tick_cnt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic             en_q, per_q;
  pit_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, match_q, reload_q;
  logic [CNT_W-1:0] step_next;
  logic             step_hit, term, pend;
  logic             wr_ctrl, wr_cnt, wr_match, wr_reload, wr_stat;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_cnt    = reg_we_i && (reg_addr_i == A_COUNT);
  assign wr_match  = reg_we_i && (reg_addr_i == A_MATCH);
  assign wr_reload = reg_we_i && (reg_addr_i == A_RELOAD);
  assign wr_stat   = reg_we_i && (reg_addr_i == A_STATUS);

  pit_step #(.CNT_W(CNT_W), .TICK_W(TICK_W), .MAX_STEP(MAX_STEP)) u_step (
    .cnt_i   (cnt_q),
    .match_i (match_q),
    .mode_i  (mode_q),
    .tick_i  (tick_cnt_i),
    .next_o  (step_next),
    .hit_o   (step_hit)
  );

  // software count write wins over the tick in the same cycle
  assign term = en_q && !wr_cnt && step_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      mode_q <= MODE_DOWN;
    end else if (wr_ctrl) begin
      en_q   <= reg_wdata_i[0];
      mode_q <= pit_mode_e'(reg_wdata_i[2:1]);
      per_q  <= reg_wdata_i[3];
    end else if (term && !per_q) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= reg_wdata_i;
    end else if (term) begin
      if (per_q)              cnt_q <= reload_q;
      else if (mode_q[1])     cnt_q <= step_next;
      else                    cnt_q <= '0;
    end else if (en_q) begin
      cnt_q <= step_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_match)  match_q  <= reg_wdata_i;
      if (wr_reload) reload_q <= reg_wdata_i;
    end
  end

  pit_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (term),
    .clr_i  (wr_stat && reg_wdata_i[0]),
    .pend_o (pend)
  );

  assign irq_o = pend;

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = CNT_W'({per_q, mode_q, en_q});
      A_COUNT:  reg_rdata_o = cnt_q;
      A_MATCH:  reg_rdata_o = match_q;
      A_RELOAD: reg_rdata_o = reload_q;
      A_STATUS: reg_rdata_o = CNT_W'(pend);
      default:  reg_rdata_o = '0;
    endcase
  end

  p_cnt_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt_q == $past(reg_wdata_i));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !wr_cnt |=> $stable(cnt_q));
  p_oneshot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term && !per_q && !wr_ctrl |=> !en_q);
  p_periodic_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term && per_q && !wr_ctrl |=> en_q && cnt_q == $past(reload_q));
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pit_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_cnt_i  (tick),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  localparam logic [2:0] CTRL = 3'd0, CNT = 3'd1, MATCH = 3'd2, RELOAD = 3'd3, STAT = 3'd4;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: optional write and tick, applied at the next rising edge
  task automatic cyc(input bit w, input logic [2:0] a, input logic [63:0] d, input logic [4:0] t);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    we = 1'b0; tick = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    cyc(1'b1, a, d, 5'd0);
  endtask

  task automatic run(input logic [4:0] t);
    cyc(1'b0, 3'd0, 64'd0, t);
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(CTRL, v);   chk("R1 ctrl", v, 0);
    rd(CNT, v);    chk("R1 count", v, 0);
    rd(MATCH, v);  chk("R1 match", v, 0);
    rd(RELOAD, v); chk("R1 reload", v, 0);
    chk("R1 irq", irq, 0);
    rd(3'd7, v);   chk("R10 unmapped", v, 0);
  endtask

  task automatic t_down;
    logic [63:0] v;
    wr(CNT, 64'd10);
    wr(CTRL, 64'h1);
    run(5'd3); run(5'd3); run(5'd3);
    rd(CNT, v); chk("R2 down count", v, 64'd1);
    chk("R2 no early irq", irq, 0);
    run(5'd3);
    rd(CNT, v); chk("R6 oneshot down zero", v, 0);
    chk("R2 down terminal irq", irq, 1);
    rd(CTRL, v); chk("R6 enable cleared", v, 64'h0);
  endtask

  task automatic t_ack;
    logic [63:0] v;
    wr(STAT, 64'h0);
    chk("R8 write 0 keeps irq", irq, 1);
    rd(STAT, v); chk("R10 status pending", v, 1);
    wr(STAT, 64'h1);
    chk("R8 ack clears irq", irq, 0);
  endtask

  task automatic t_up;
    logic [63:0] v;
    wr(RELOAD, -64'sd5);
    wr(CNT, -64'sd5);
    wr(CTRL, 64'hB);
    run(5'd2); run(5'd2);
    rd(CNT, v); chk("R3 up count", v, -64'sd1);
    chk("R3 no irq at -1", irq, 0);
    run(5'd2);
    rd(CNT, v); chk("R7 periodic reload", v, -64'sd5);
    chk("R3 up terminal irq", irq, 1);
    rd(CTRL, v); chk("R7 enable kept", v, 64'hB);
    wr(CTRL, 64'h0);
    wr(STAT, 64'h1);
  endtask

  task automatic t_clamp;
    logic [63:0] v;
    wr(CNT, 64'd100);
    wr(CTRL, 64'h1);
    run(5'd31);
    rd(CNT, v); chk("R5 tick saturates", v, 64'd84);
    wr(CTRL, 64'h0);
  endtask

  task automatic t_idle;
    logic [63:0] v;
    run(5'd16);
    rd(CNT, v); chk("R11 disabled holds", v, 64'd84);
  endtask

  task automatic t_cmp;
    logic [63:0] v;
    wr(MATCH, 64'd50);
    wr(CNT, 64'd40);
    wr(CTRL, 64'h5);
    run(5'd9);
    rd(CNT, v); chk("R4 compare below", v, 64'd49);
    chk("R4 no irq below match", irq, 0);
    run(5'd1);
    rd(CNT, v); chk("R6 oneshot compare value", v, 64'd50);
    chk("R4 compare hit irq", irq, 1);
    rd(CTRL, v); chk("R6 compare enable cleared", v, 64'h4);
    wr(STAT, 64'h1);
  endtask

  task automatic t_prio;
    logic [63:0] v;
    wr(CNT, 64'd3);
    wr(CTRL, 64'h1);
    cyc(1'b1, CNT, 64'd1000, 5'd16);
    rd(CNT, v); chk("R9 write wins", v, 64'd1000);
    chk("R9 dropped tick no irq", irq, 0);
    rd(CNT, v);
    wr(CNT, v + 64'd7);
    rd(CNT, v); chk("R9 resync exact", v, 64'd1007);
    wr(CTRL, 64'h0);
  endtask

  task automatic t_set_clr;
    wr(CNT, 64'd2);
    wr(CTRL, 64'h1);
    run(5'd2);
    chk("R8 pending", irq, 1);
    wr(CNT, 64'd2);
    wr(CTRL, 64'h1);
    cyc(1'b1, STAT, 64'h1, 5'd2);
    chk("R8 set beats clear", irq, 1);
    wr(STAT, 64'h1);
    chk("R8 cleared after", irq, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_down;
    t_ack;
    t_up;
    t_clamp;
    t_idle;
    t_cmp;
    t_prio;
    t_set_clr;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule